// File: doc/BRIEF.md
# Watchpoint-Triggered Fault Injector

This block lives inside the on-chip debug logic next to a processor's memory bus. Debug logic loads it with three things: a trigger address, a target RAM address, and a replacement byte. The replacement byte is computed beforehand so that writing it leaves exactly one bit different from what the target cell holds at the injection instant.

Once armed, the block watches instruction fetches, data accesses, or both. A match raises a watchpoint-hit pulse. The block then requests the data bus and, as soon as the bus arbiter grants a free slot, writes the replacement byte without stopping the processor. Trace and program execution carry on untouched.

Each arming fires at most once. A done pulse marks the committed write, and the block disarms itself at the same moment. While the write is still pending, a processor store to the same target cell could overwrite the fault, so the block flags that experiment as inconclusive. A reset of the target processor drops the arming unless the arming was loaded with a keep option.

Top module: `fault_trig_inj`

## Requirements
- R1: After rst_n is asserted, armed, wp_hit, inj_req, inj_done and inconclusive are all 0.
- R2: Arming with cfg_kind bit 0 set makes a fetch whose address equals the trigger address raise wp_hit for one cycle, on the clock edge after the fetch.
- R3: Arming with cfg_kind bit 1 set makes a data access (read or write) whose address equals the trigger address raise wp_hit for one cycle, on the clock edge after the access.
- R4: An access on a class whose cfg_kind bit is 0, or at any other address, raises no wp_hit and leaves the block armed.
- R5: From the cycle wp_hit is high, inj_req is high, with inj_addr equal to the armed target address and inj_wdata equal to the armed replacement byte. The write commits on the first clock edge with inj_req and inj_gnt both high, so with a free bus it commits one cycle after the trigger.
- R6: While inj_gnt is low, inj_req stays high and inj_addr and inj_wdata stay unchanged.
- R7: The edge that commits the write raises inj_done for exactly one cycle and clears both armed and inj_req. A later matching access causes no second write.
- R8: A data write by the processor to the target address while inj_req is high sets inconclusive from the next edge. The flag stays set until the next arming clears it, and it stays 0 when no such write occurs.
- R9: A cpu_rst pulse while armed clears armed when the arming was loaded with cfg_keep = 0, and the block then ignores matches. With cfg_keep = 1 the block stays armed and still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| cpu_rst | input | 1 | Target processor reset indication |
| cfg_arm | input | 1 | One-cycle pulse: load the configuration and arm |
| cfg_kind | input | 2 | Trigger class enables: bit 0 fetch, bit 1 data access |
| cfg_trig_addr | input | AW | Trigger address |
| cfg_tgt_addr | input | AW | RAM address that receives the fault |
| cfg_value | input | DW | Replacement byte written on trigger |
| cfg_keep | input | 1 | Keep the arming across cpu_rst |
| fetch_valid | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | AW | Fetch address |
| data_valid | input | 1 | Processor data access in this cycle |
| data_we | input | 1 | Processor data access is a write |
| data_addr | input | AW | Processor data address |
| inj_gnt | input | 1 | Bus grant to the injector for this cycle |
| armed | output | 1 | Waiting for the trigger |
| wp_hit | output | 1 | Watchpoint hit pulse |
| inj_req | output | 1 | Injection write requested |
| inj_addr | output | AW | Injection write address |
| inj_wdata | output | DW | Injection write data |
| inj_done | output | 1 | Injection write committed (pulse) |
| inconclusive | output | 1 | Target cell was written by the processor before the fault landed |

## Verification
A corrupted state register shows up within one cycle of the next matching access. The symptom is a missing or extra wp_hit, or an inj_req that appears without a trigger or never drops after a grant. The scoreboard checks every committed write against the queued expectation, so a wrong latched target or value, or a duplicate write, is caught at the commit edge. Flag errors are visible on the cycle after the conflicting store or the next arming.

// File: rtl/fti_pkg.sv
package fti_pkg;
    localparam int NCH      = 2;
    localparam int CH_FETCH = 0;
    localparam int CH_DATA  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PEND  = 2'd2
    } fti_state_e;
endpackage

// File: rtl/fti_match.sv
module fti_match #(
    parameter int AW = 16
) (
    input  logic          en,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_addr,
    output logic          hit
);
    always_comb hit = en && valid && (addr == ref_addr);
endmodule

// File: rtl/fti_conflict.sv
module fti_conflict #(
    parameter int AW = 16
) (
    input  logic          watch,
    input  logic          valid,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] tgt,
    output logic          clash
);
    always_comb clash = watch && valid && we && (addr == tgt);
endmodule

// File: rtl/fti_ctrl.sv
module fti_ctrl
    import fti_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_rst,
    input  logic           cfg_arm,
    input  logic [NCH-1:0] cfg_kind,
    input  logic [AW-1:0]  cfg_trig_addr,
    input  logic [AW-1:0]  cfg_tgt_addr,
    input  logic [DW-1:0]  cfg_value,
    input  logic           cfg_keep,
    input  logic [NCH-1:0] ch_hit,
    input  logic           clash,
    input  logic           inj_gnt,
    output logic [NCH-1:0] kind_en,
    output logic [AW-1:0]  trig_addr,
    output logic [AW-1:0]  tgt_addr,
    output logic           pending,
    output logic           armed,
    output logic           wp_hit,
    output logic [DW-1:0]  wdata,
    output logic           done,
    output logic           incon
);
    typedef struct packed {
        fti_state_e     st;
        logic [NCH-1:0] kind;
        logic [AW-1:0]  trig;
        logic [AW-1:0]  tgt;
        logic [DW-1:0]  val;
        logic           keep;
        logic           hit;
        logic           done;
        logic           incon;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.hit  = 1'b0;
        r_d.done = 1'b0;
        if (cfg_arm) begin
            r_d.st    = ST_ARMED;
            r_d.kind  = cfg_kind;
            r_d.trig  = cfg_trig_addr;
            r_d.tgt   = cfg_tgt_addr;
            r_d.val   = cfg_value;
            r_d.keep  = cfg_keep;
            r_d.incon = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ARMED: begin
                    if (cpu_rst && !r_q.keep) begin
                        r_d.st = ST_IDLE;
                    end else if (|ch_hit) begin
                        r_d.st  = ST_PEND;
                        r_d.hit = 1'b1;
                    end
                end
                ST_PEND: begin
                    if (clash) r_d.incon = 1'b1;
                    if (inj_gnt) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else if (cpu_rst && !r_q.keep) begin
                        r_d.st = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign kind_en   = r_q.kind;
    assign trig_addr = r_q.trig;
    assign tgt_addr  = r_q.tgt;
    assign pending   = (r_q.st == ST_PEND);
    assign armed     = (r_q.st == ST_ARMED);
    assign wp_hit    = r_q.hit;
    assign wdata     = r_q.val;
    assign done      = r_q.done;
    assign incon     = r_q.incon;
endmodule

// File: rtl/fault_trig_inj.sv
module fault_trig_inj
    import fti_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_rst,
    input  logic           cfg_arm,
    input  logic [NCH-1:0] cfg_kind,
    input  logic [AW-1:0]  cfg_trig_addr,
    input  logic [AW-1:0]  cfg_tgt_addr,
    input  logic [DW-1:0]  cfg_value,
    input  logic           cfg_keep,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic           data_valid,
    input  logic           data_we,
    input  logic [AW-1:0]  data_addr,
    input  logic           inj_gnt,
    output logic           armed,
    output logic           wp_hit,
    output logic           inj_req,
    output logic [AW-1:0]  inj_addr,
    output logic [DW-1:0]  inj_wdata,
    output logic           inj_done,
    output logic           inconclusive
);
    logic [NCH-1:0]         acc_valid;
    logic [NCH-1:0][AW-1:0] acc_addr;
    logic [NCH-1:0]         ch_hit;
    logic [NCH-1:0]         kind_en;
    logic [AW-1:0]          trig_addr;
    logic                   clash;

    always_comb begin
        acc_valid           = '0;
        acc_addr            = '0;
        acc_valid[CH_FETCH] = fetch_valid;
        acc_addr[CH_FETCH]  = fetch_addr;
        acc_valid[CH_DATA]  = data_valid;
        acc_addr[CH_DATA]   = data_addr;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_watch
        fti_match #(.AW(AW)) match_i (
            .en       (kind_en[ch]),
            .valid    (acc_valid[ch]),
            .addr     (acc_addr[ch]),
            .ref_addr (trig_addr),
            .hit      (ch_hit[ch])
        );
    end

    fti_conflict #(.AW(AW)) conflict_i (
        .watch (inj_req),
        .valid (data_valid),
        .we    (data_we),
        .addr  (data_addr),
        .tgt   (inj_addr),
        .clash (clash)
    );

    fti_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_rst       (cpu_rst),
        .cfg_arm       (cfg_arm),
        .cfg_kind      (cfg_kind),
        .cfg_trig_addr (cfg_trig_addr),
        .cfg_tgt_addr  (cfg_tgt_addr),
        .cfg_value     (cfg_value),
        .cfg_keep      (cfg_keep),
        .ch_hit        (ch_hit),
        .clash         (clash),
        .inj_gnt       (inj_gnt),
        .kind_en       (kind_en),
        .trig_addr     (trig_addr),
        .tgt_addr      (inj_addr),
        .pending       (inj_req),
        .armed         (armed),
        .wp_hit        (wp_hit),
        .wdata         (inj_wdata),
        .done          (inj_done),
        .incon         (inconclusive)
    );
endmodule

// File: rtl/fti_chk.sv
module fti_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_rst,
    input logic          cfg_arm,
    input logic          inj_gnt,
    input logic          armed,
    input logic          wp_hit,
    input logic          inj_req,
    input logic [AW-1:0] inj_addr,
    input logic [DW-1:0] inj_wdata,
    input logic          inj_done,
    input logic          inconclusive
);
    assert_hit_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wp_hit |-> inj_req);

    assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req && !inj_gnt && !cfg_arm && !cpu_rst
        |=> inj_req && $stable(inj_addr) && $stable(inj_wdata));

    assert_commit_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req && inj_gnt && !cfg_arm |=> inj_done && !inj_req && !armed);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inj_done |=> !inj_done);

    assert_incon_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inconclusive && !cfg_arm |=> inconclusive);

    assert_done_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_done) |-> $past(inj_req && inj_gnt));
endmodule

bind fault_trig_inj fti_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_rst      (cpu_rst),
    .cfg_arm      (cfg_arm),
    .inj_gnt      (inj_gnt),
    .armed        (armed),
    .wp_hit       (wp_hit),
    .inj_req      (inj_req),
    .inj_addr     (inj_addr),
    .inj_wdata    (inj_wdata),
    .inj_done     (inj_done),
    .inconclusive (inconclusive)
);

// File: tb/fault_trig_inj_tb_top.sv
module fault_trig_inj_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rst = 1'b0;
    logic          cfg_arm = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [AW-1:0] cfg_trig_addr = '0;
    logic [AW-1:0] cfg_tgt_addr = '0;
    logic [DW-1:0] cfg_value = '0;
    logic          cfg_keep = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          data_valid = 1'b0;
    logic          data_we = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic          inj_gnt;
    logic          armed, wp_hit, inj_req, inj_done, inconclusive;
    logic [AW-1:0] inj_addr;
    logic [DW-1:0] inj_wdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
    wr_t exp_q[$];

    always #2.5 clk = ~clk;

    // Bus arbiter: processor data access has priority, injector gets idle slots.
    assign inj_gnt = inj_req && !data_valid;

    fault_trig_inj #(.AW(AW), .DW(DW)) dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Monitor: a write commits at the next edge when req and grant are both high.
    always @(negedge clk) begin
        #1;
        if (rst_n && inj_req && inj_gnt) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected write", 32'(inj_addr), 32'hFFFF_FFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check("R5 write addr", 32'(inj_addr), 32'(e.a));
                check("R5 write data", 32'(inj_wdata), 32'(e.d));
            end
        end
    end

    task automatic arm(logic [1:0] kind, logic [AW-1:0] trig, logic [AW-1:0] tgt,
                       logic [DW-1:0] val, logic keep);
        cfg_arm = 1; cfg_kind = kind; cfg_trig_addr = trig;
        cfg_tgt_addr = tgt; cfg_value = val; cfg_keep = keep;
        @(negedge clk);
        cfg_arm = 0;
    endtask

    task automatic expect_write(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_t e;
        e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic fetch(logic [AW-1:0] a);
        fetch_valid = 1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 0;
    endtask

    task automatic pulse_cpu_rst();
        cpu_rst = 1;
        @(negedge clk);
        cpu_rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 armed", 32'(armed), 0);
        check("R1 wp_hit", 32'(wp_hit), 0);
        check("R1 inj_req", 32'(inj_req), 0);
        check("R1 inj_done", 32'(inj_done), 0);
        check("R1 inconclusive", 32'(inconclusive), 0);
        rst_n = 1;
        @(negedge clk);

        // Fetch trigger, free bus
        arm(2'b01, 16'h0040, 16'h0010, 8'hA5, 0);
        check("R2 armed after arm", 32'(armed), 1);
        expect_write(16'h0010, 8'hA5);
        fetch(16'h0040);
        check("R2 wp_hit", 32'(wp_hit), 1);
        check("R5 inj_req", 32'(inj_req), 1);
        @(negedge clk);
        check("R7 done", 32'(inj_done), 1);
        check("R7 disarmed", 32'(armed), 0);
        check("R7 req dropped", 32'(inj_req), 0);
        check("R8 no conflict", 32'(inconclusive), 0);
        @(negedge clk);
        check("R7 done single", 32'(inj_done), 0);
        fetch(16'h0040);
        check("R7 no refire hit", 32'(wp_hit), 0);
        check("R7 no refire req", 32'(inj_req), 0);

        // Data trigger, bus busy for three cycles
        arm(2'b10, 16'h0080, 16'h0022, 8'h3C, 0);
        expect_write(16'h0022, 8'h3C);
        data_valid = 1; data_we = 0; data_addr = 16'h0080;
        @(negedge clk);
        check("R3 wp_hit", 32'(wp_hit), 1);
        data_addr = 16'h0090;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 req held", 32'(inj_req), 1);
            check("R6 addr held", 32'(inj_addr), 32'h0022);
            check("R6 no done", 32'(inj_done), 0);
        end
        data_valid = 0;
        @(negedge clk);
        check("R7 done after grant", 32'(inj_done), 1);
        check("R8 read no flag", 32'(inconclusive), 0);

        // Disabled class and wrong address, then processor reset without keep
        arm(2'b10, 16'h0040, 16'h0012, 8'h55, 0);
        fetch(16'h0040);
        check("R4 fetch ignored", 32'(wp_hit), 0);
        check("R4 still armed", 32'(armed), 1);
        data_valid = 1; data_addr = 16'h0041;
        @(negedge clk);
        data_valid = 0;
        check("R4 other addr", 32'(wp_hit), 0);
        pulse_cpu_rst();
        check("R9 cleared", 32'(armed), 0);
        data_valid = 1; data_addr = 16'h0040;
        @(negedge clk);
        data_valid = 0;
        check("R9 ignored after clear", 32'(wp_hit), 0);
        check("R9 no req", 32'(inj_req), 0);

        // Keep across processor reset
        arm(2'b01, 16'h0044, 16'h0011, 8'h7E, 1);
        pulse_cpu_rst();
        check("R9 kept", 32'(armed), 1);
        expect_write(16'h0011, 8'h7E);
        fetch(16'h0044);
        check("R9 fires after keep", 32'(wp_hit), 1);
        @(negedge clk);
        check("R9 done after keep", 32'(inj_done), 1);

        // Processor writes the target first
        arm(2'b01, 16'h0048, 16'h0030, 8'h01, 0);
        expect_write(16'h0030, 8'h01);
        fetch(16'h0048);
        data_valid = 1; data_we = 1; data_addr = 16'h0030;
        @(negedge clk);
        data_valid = 0; data_we = 0;
        check("R8 flag set", 32'(inconclusive), 1);
        @(negedge clk);
        check("R8 done", 32'(inj_done), 1);
        check("R8 flag held", 32'(inconclusive), 1);
        arm(2'b00, 16'h0000, 16'h0000, 8'h00, 0);
        check("R8 cleared by arm", 32'(inconclusive), 0);

        repeat (2) @(negedge clk);
        check("R5 all writes seen", 32'(exp_q.size()), 0);
        report();
    end
endmodule